// File: doc/BRIEF.md
# Ring Oscillator Response Bit Generator

This block derives response bits from a grid of ring oscillators laid out in rows and columns. It measures one row at a time. It switches on every oscillator in the selected row together, and each column's oscillator feeds a dedicated edge counter. All counters run for the same fixed gate window. When the window closes, the block compares the counts of neighbouring columns pairwise. Each comparison yields one bit, and the bits are streamed out serially with a valid strobe.

Only adjacent columns are ever compared. A row of `COLS` oscillators therefore yields `COLS-1` bits, and no bit is implied by other bits through transitive ordering. The default array is 256 rows by 16 columns, which gives 3840 bits per full evaluation.

Oscillator outputs reach the block asynchronously. Each one passes through a two-flop synchronizer, and only its rising edges are counted.

The control state machine has six states:

| State | Role |
|---|---|
| `ST_IDLE` | Waits for a start pulse. |
| `ST_ARM` | Clears the counters and raises the oscillator enable for one cycle. |
| `ST_WINDOW` | Counts for `WIN_CYCLES` cycles. |
| `ST_LATCH` | Drops the enable and captures the comparison result. |
| `ST_STREAM` | Emits one bit per cycle. |
| `ST_DONE` | Holds the completion flag. |

The transitions are:

| Transition | Condition |
|---|---|
| `ST_IDLE` → `ST_ARM` | A start pulse arrives. |
| `ST_DONE` → `ST_ARM` | A start pulse arrives. |
| `ST_ARM` → `ST_WINDOW` | Always, after one cycle. |
| `ST_WINDOW` → `ST_LATCH` | The window count expires. |
| `ST_LATCH` → `ST_STREAM` | Always, after one cycle. |
| `ST_STREAM` → `ST_ARM` | The last pair of a row that is not the final row. |
| `ST_STREAM` → `ST_DONE` | The last pair of the final row. |

Top module: `ro_puf_resp_gen`

## Requirements
- R1: After reset, `osc_en`, `bit_valid`, `busy` and `done` are 0 and `osc_row` is 0.
- R2: A start pulse in idle or done begins measurement of row 0. On the next cycle `osc_en` is 1 and `osc_row` is 0. `osc_en` is 0 in every cycle where `bit_valid` is 1.
- R3: For each row, `osc_en` stays high for exactly `WIN_CYCLES+1` consecutive cycles: one arm cycle plus the gate window. `osc_row` does not change while `osc_en` is high. Counters are cleared before every row, so counts from one row never carry into the next.
- R4: The bit for pair i is 1 when column i counted more rising edges than column i+1. Otherwise it is 0, and equal counts give 0.
- R5: Each counter is `CNT_W` bits wide and saturates at 2^`CNT_W`-1. Two columns that both reach the ceiling compare equal and give 0.
- R6: Bits of a row come out on consecutive cycles, pair 0 first. `bit_col` runs from 0 to `COLS-2`, and `osc_row` gives the row. Rows are processed in ascending order.
- R7: A run emits exactly `ROWS*(COLS-1)` bits. After the last bit of the final row, `done` is 1, and `busy`, `osc_en` and `bit_valid` are 0.
- R8: A start pulse while `busy` is 1 is ignored, and the run continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to evaluate the whole array |
| osc_in | input | COLS | Asynchronous oscillator outputs of the selected row, one per column |
| osc_en | output | 1 | Enable for the oscillators of the selected row |
| osc_row | output | ROW_W | Row currently selected and being reported |
| bit_valid | output | 1 | Strobe for `bit_data` |
| bit_data | output | 1 | Response bit for pair (`bit_col`, `bit_col`+1) |
| bit_col | output | COL_W | Index of the left column of the compared pair |
| busy | output | 1 | High from start until completion |
| done | output | 1 | High after the final bit, until the next start |

## Verification
The bench builds the block with 4 rows and 5 columns, a 5-bit counter and a 200-cycle window. With these values a whole run takes under a thousand cycles, and rows can be stepped through several times. The small counter width means a 4000 ns window lets fast oscillator periods reach the 31-count ceiling, so saturation and equal-count comparisons occur with realistic periods. The bench's oscillator models start on the rising enable, change period with the selected row, and stop when the enable drops. This makes the per-row clearing and the gating visible in the output bits.

// File: rtl/ro_puf_pkg.sv
package ro_puf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ARM    = 3'd1,
        ST_WINDOW = 3'd2,
        ST_LATCH  = 3'd3,
        ST_STREAM = 3'd4,
        ST_DONE   = 3'd5
    } scan_state_t;

endpackage

// File: rtl/ro_col_counter.sv
module ro_col_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_raw,
    input  logic             clr,
    input  logic             cnt_en,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic meta_q;
    logic sync_q;
    logic prev_q;
    logic rise;

    // two-flop synchronizer plus one stage for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= osc_raw;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise = sync_q & ~prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (cnt_en && rise && (count != CNT_MAX)) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/ro_pair_compare.sv
module ro_pair_compare #(
    parameter int COLS  = 16,
    parameter int CNT_W = 16
) (
    input  logic [COLS*CNT_W-1:0] counts,
    output logic [COLS-2:0]       pair_bits
);
    generate
        for (genvar i = 0; i < COLS - 1; i++) begin : g_pair
            logic [CNT_W-1:0] left_cnt;
            logic [CNT_W-1:0] right_cnt;
            assign left_cnt     = counts[i*CNT_W +: CNT_W];
            assign right_cnt    = counts[(i+1)*CNT_W +: CNT_W];
            assign pair_bits[i] = (left_cnt > right_cnt);
        end
    endgenerate

endmodule

// File: rtl/ro_scan_fsm.sv
module ro_scan_fsm
    import ro_puf_pkg::*;
#(
    parameter int ROWS       = 256,
    parameter int COLS       = 16,
    parameter int WIN_CYCLES = 4096,
    localparam int ROW_W     = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int COL_W     = (COLS > 2) ? $clog2(COLS) : 1,
    localparam int WIN_W     = $clog2(WIN_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             clr,
    output logic             cnt_en,
    output logic             osc_en,
    output logic             load,
    output logic             bit_valid,
    output logic             busy,
    output logic             done,
    output logic [ROW_W-1:0] row_idx,
    output logic [COL_W-1:0] col_idx
);
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYCLES - 1);
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 2);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

    scan_state_t state_q;
    scan_state_t state_d;
    logic [WIN_W-1:0] win_q;
    logic             win_end;
    logic             col_end;
    logic             row_end;

    assign win_end = (win_q == WIN_LAST);
    assign col_end = (col_idx == COL_LAST);
    assign row_end = (row_idx == ROW_LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_ARM;
            ST_ARM:    state_d = ST_WINDOW;
            ST_WINDOW: if (win_end) state_d = ST_LATCH;
            ST_LATCH:  state_d = ST_STREAM;
            ST_STREAM: if (col_end) state_d = row_end ? ST_DONE : ST_ARM;
            ST_DONE:   if (start) state_d = ST_ARM;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from the current state
    always_comb begin
        clr       = 1'b0;
        cnt_en    = 1'b0;
        osc_en    = 1'b0;
        load      = 1'b0;
        bit_valid = 1'b0;
        busy      = 1'b1;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE:   busy = 1'b0;
            ST_ARM: begin
                clr    = 1'b1;
                osc_en = 1'b1;
            end
            ST_WINDOW: begin
                osc_en = 1'b1;
                cnt_en = 1'b1;
            end
            ST_LATCH:  load = 1'b1;
            ST_STREAM: bit_valid = 1'b1;
            ST_DONE: begin
                busy = 1'b0;
                done = 1'b1;
            end
            default:   busy = 1'b0;
        endcase
    end

    // window, column and row counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q   <= '0;
            col_idx <= '0;
            row_idx <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        row_idx <= '0;
                    end
                    win_q   <= '0;
                    col_idx <= '0;
                end
                ST_ARM: begin
                    win_q <= '0;
                end
                ST_WINDOW: begin
                    win_q <= win_q + 1'b1;
                end
                ST_LATCH: begin
                    col_idx <= '0;
                end
                ST_STREAM: begin
                    if (col_end) begin
                        col_idx <= '0;
                        if (!row_end) begin
                            row_idx <= row_idx + 1'b1;
                        end
                    end else begin
                        col_idx <= col_idx + 1'b1;
                    end
                end
                default: begin
                    win_q <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/ro_puf_resp_gen.sv
module ro_puf_resp_gen #(
    parameter int ROWS       = 256,
    parameter int COLS       = 16,
    parameter int CNT_W      = 16,
    parameter int WIN_CYCLES = 4096,
    localparam int ROW_W     = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int COL_W     = (COLS > 2) ? $clog2(COLS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [COLS-1:0]  osc_in,
    output logic             osc_en,
    output logic [ROW_W-1:0] osc_row,
    output logic             bit_valid,
    output logic             bit_data,
    output logic [COL_W-1:0] bit_col,
    output logic             busy,
    output logic             done
);
    logic                  clr;
    logic                  cnt_en;
    logic                  load;
    logic [COLS*CNT_W-1:0] counts;
    logic [COLS-2:0]       pair_bits;
    logic [COLS-2:0]       resp_q;

    ro_scan_fsm #(
        .ROWS      (ROWS),
        .COLS      (COLS),
        .WIN_CYCLES(WIN_CYCLES)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .clr      (clr),
        .cnt_en   (cnt_en),
        .osc_en   (osc_en),
        .load     (load),
        .bit_valid(bit_valid),
        .busy     (busy),
        .done     (done),
        .row_idx  (osc_row),
        .col_idx  (bit_col)
    );

    generate
        for (genvar c = 0; c < COLS; c++) begin : g_col
            ro_col_counter #(
                .CNT_W(CNT_W)
            ) u_cnt (
                .clk    (clk),
                .rst_n  (rst_n),
                .osc_raw(osc_in[c]),
                .clr    (clr),
                .cnt_en (cnt_en),
                .count  (counts[c*CNT_W +: CNT_W])
            );
        end
    endgenerate

    ro_pair_compare #(
        .COLS (COLS),
        .CNT_W(CNT_W)
    ) u_cmp (
        .counts   (counts),
        .pair_bits(pair_bits)
    );

    // capture the row result, then shift out pair 0 first
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_q <= '0;
        end else if (load) begin
            resp_q <= pair_bits;
        end else if (bit_valid) begin
            resp_q <= resp_q >> 1;
        end
    end

    assign bit_data = resp_q[0];

endmodule

// File: rtl/ro_puf_resp_gen_chk.sv
module ro_puf_resp_gen_chk #(
    parameter int ROWS   = 256,
    parameter int COLS   = 16,
    localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int COL_W = (COLS > 2) ? $clog2(COLS) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             osc_en,
    input logic [ROW_W-1:0] osc_row,
    input logic             bit_valid,
    input logic [COL_W-1:0] bit_col,
    input logic             busy,
    input logic             done
);
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 2);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

    AST_EN_OFF_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> !osc_en); // R2

    AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_en && $past(osc_en)) |-> $stable(osc_row)); // R3

    AST_FIRST_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bit_valid) |-> (bit_col == '0)); // R6

    AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && $past(bit_valid) && ($past(bit_col) != COL_LAST))
            |-> (bit_col == COL_W'($past(bit_col) + 1'b1))); // R6

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!bit_valid && !osc_en && !busy)); // R7

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(bit_valid) && ($past(bit_col) == COL_LAST)
                         && ($past(osc_row) == ROW_LAST))); // R7

endmodule

bind ro_puf_resp_gen ro_puf_resp_gen_chk #(
    .ROWS(ROWS),
    .COLS(COLS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .osc_en   (osc_en),
    .osc_row  (osc_row),
    .bit_valid(bit_valid),
    .bit_col  (bit_col),
    .busy     (busy),
    .done     (done)
);

// File: tb/ro_puf_resp_gen_tb.sv
`timescale 1ns/1ps
module ro_puf_resp_gen_tb;
    localparam int ROWS  = 4;
    localparam int COLS  = 5;
    localparam int CNT_W = 5;
    localparam int WIN   = 200;
    localparam int ROW_W = $clog2(ROWS);
    localparam int COL_W = $clog2(COLS);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [COLS-1:0]  osc;
    logic             osc_en;
    logic [ROW_W-1:0] osc_row;
    logic             bit_valid;
    logic             bit_data;
    logic [COL_W-1:0] bit_col;
    logic             busy;
    logic             done;

    int checks = 0;
    int errors = 0;
    int pat = 0;
    int cycles = 0;
    bit wd_hit = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    ro_puf_resp_gen #(
        .ROWS(ROWS), .COLS(COLS), .CNT_W(CNT_W), .WIN_CYCLES(WIN)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .osc_in(osc),
        .osc_en(osc_en), .osc_row(osc_row), .bit_valid(bit_valid),
        .bit_data(bit_data), .bit_col(bit_col), .busy(busy), .done(done)
    );

    function automatic int pick(int i);
        case (i)
            0: return 40;
            1: return 100;
            2: return 150;
            3: return 250;
            default: return 400;
        endcase
    endfunction

    // half period in ns of oscillator (row r, column c) under pattern p
    function automatic int half_ns(int p, int r, int c);
        if (p == 0) return pick((r * 3 + c * 2) % 5);
        if (p == 1) return pick((r + c * 4) % 5);
        if (r % 2 == 0) return (c % 2 == 0) ? 40 : 50;
        return 150;
    endfunction

    // pattern 2: 40/50 ns both exceed the 31-count ceiling, 150 ns is uniform
    function automatic bit exp_bit(int p, int r, int c);
        if (p == 2) return 1'b0;
        return half_ns(p, r, c) < half_ns(p, r, c + 1);
    endfunction

    generate
        for (genvar g = 0; g < COLS; g++) begin : g_osc
            logic o_q = 1'b0;
            always begin
                if (!osc_en) begin
                    o_q = 1'b0;
                    @(posedge osc_en);
                    #7;
                end else begin
                    #(half_ns(pat, int'(osc_row), g));
                    if (osc_en) o_q = ~o_q;
                end
            end
            assign osc[g] = o_q;
        end
    endgenerate

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic test_reset();
        @(negedge clk);
        check("R1 osc_en", osc_en, 0);
        check("R1 bit_valid", bit_valid, 0);
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 osc_row", osc_row, 0);
    endtask

    task automatic run_pattern(int p, bit inject_start);
        int k = 0;
        int en_len = 0;
        bit first_row = 1'b1;
        pat = p;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R2 enable after start", osc_en, 1);
        check("R2 first row", osc_row, 0);
        while (!done && !wd_hit) begin
            if (osc_en && first_row) en_len++;
            if (bit_valid) begin
                if (first_row) begin
                    check("R3 window length", en_len, WIN + 1);
                    first_row = 1'b0;
                end
                check("R2 enable off while streaming", osc_en, 0);
                check("R6 row", osc_row, k / (COLS - 1));
                check("R6 col", bit_col, k % (COLS - 1));
                if (p == 2)
                    check("R5 saturated/equal bit", bit_data,
                          exp_bit(p, k / (COLS - 1), k % (COLS - 1)));
                else
                    check("R4 bit", bit_data,
                          exp_bit(p, k / (COLS - 1), k % (COLS - 1)));
                k++;
            end
            if (inject_start && k == 3) start = 1'b1;
            else start = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
        if (inject_start) check("R8 start ignored, bit total", k, ROWS * (COLS - 1));
        else check("R7 bit total", k, ROWS * (COLS - 1));
        check("R7 done", done, 1);
        check("R7 busy", busy, 0);
        check("R7 osc_en", osc_en, 0);
        @(negedge clk);
        check("R7 done holds", done, 1);
        check("R7 no stray bit", bit_valid, 0);
    endtask

    initial begin
        fork
            begin
                wait (cycles > 100000);
                wd_hit = 1'b1;
            end
        join_none
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        run_pattern(0, 1'b0);
        run_pattern(1, 1'b0);
        run_pattern(2, 1'b0);
        run_pattern(0, 1'b1);
        if (wd_hit) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule